// File: doc/BRIEF.md
# Serial CRC Codeword Generator and Checker

This block divides a serial bit stream by a fixed generator polynomial using carry-free (XOR) arithmetic, one bit per clock. A frame opens with a start strobe, its data bits arrive most significant first while a valid qualifier is high, and a closing strobe marks the last bit. The block then feeds K zero bits through the divider, where K is the polynomial degree. This appends the augmentation that turns the division remainder into a K-bit check sequence.

In generate mode the remainder is the check sequence to append to the data word to form the codeword. In check mode the caller also supplies the check sequence it received. Together with the remainder, the block reports whether the recomputed value differs from it. The generator polynomial and its degree are parameters. The data path is a K-bit shift register whose taps come from the polynomial.

Top module: `crc_serial_codec`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `remainder_o` is zero and `done_o`, `mismatch_o` and `busy_o` are low.
- R2: A frame's divider register starts at zero when `frame_start_i` is sampled. The bit on `bit_i` is shifted in on each later edge where `bit_valid_i` is high. Cycles with `bit_valid_i` low leave the result unchanged, so gaps between bits do not alter the remainder.
- R3: `frame_end_i` sampled high inside a frame marks the last data bit; a valid bit in that same cycle still counts. `done_o` is then high for exactly one cycle, K clock edges after the edge that sampled `frame_end_i`.
- R4: In generate mode (`check_mode_i` = 0 at start), `remainder_o` equals the remainder of (data word · x^K) divided by the generator, with subtraction as XOR. For generator 1011 the data word 11010011101100 gives 100.
- R5: In check mode (`check_mode_i` = 1 at start), `mismatch_o` is high with `done_o` exactly when the computed remainder differs from `expect_i` as sampled with `frame_end_i`. In generate mode `mismatch_o` is low with `done_o`.
- R6: `remainder_o` and `mismatch_o` change only on the edge that raises `done_o`, and they hold until the next completed frame.
- R7: Outside a frame, `bit_valid_i`, `bit_i` and `frame_end_i` are ignored. During the K zero-bit shifts, `bit_valid_i` and `bit_i` are ignored. A new `frame_start_i` aborts any frame in progress, and that frame produces no `done_o`.
- R8: `busy_o` is high from the edge after `frame_start_i` until the edge that raises `done_o`, and low otherwise.
- R9: A frame with no data bits (end strobe with no valid bit) yields a remainder of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Opens a frame, clears the divider, latches the mode |
| check_mode_i | input | 1 | 0 = generate, 1 = check; sampled with the start strobe |
| bit_valid_i | input | 1 | Qualifies `bit_i` |
| bit_i | input | 1 | Serial data bit, most significant first |
| frame_end_i | input | 1 | Marks the last data bit of the frame |
| expect_i | input | K | Received check sequence, sampled with the end strobe |
| remainder_o | output | K | Remainder of the last completed frame |
| done_o | output | 1 | One-cycle pulse when a frame result is ready |
| mismatch_o | output | 1 | Check mode: remainder differs from `expect_i` |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default parameters: degree 3 and generator 1011. This puts the hand-worked 14-bit division within reach as an exact literal. The small remainder space also makes matching and mismatching check values easy to provoke on purpose. Random frames of 1 to 40 bits, with and without idle gaps, are compared against a separate long-division model over the augmented message. Further frames cover an abort, an empty frame, noise on the idle and flush inputs, and the K-cycle latency of the done pulse.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

    // Operating mode latched at frame start
    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } crc_mode_e;

    // Sequencer phase
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DATA  = 2'd1,
        PH_FLUSH = 2'd2
    } crc_phase_e;

    // Command from the sequencer to the divider register
    typedef struct packed {
        logic clr;   // load zero
        logic en;    // shift one bit
        logic din;   // bit entering at the bottom
    } shift_cmd_t;

    localparam shift_cmd_t SHIFT_IDLE = '{clr: 1'b0, en: 1'b0, din: 1'b0};

    function automatic shift_cmd_t mk_shift(input logic din);
        shift_cmd_t c;
        c.clr = 1'b0;
        c.en  = 1'b1;
        c.din = din;
        return c;
    endfunction

    function automatic shift_cmd_t mk_clear();
        shift_cmd_t c;
        c.clr = 1'b1;
        c.en  = 1'b0;
        c.din = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/crc_shift_core.sv
module crc_shift_core
    import crc_serial_pkg::*;
#(
    parameter int       K   = 3,
    parameter logic [K:0] GEN = 4'b1011
) (
    input  logic         clk,
    input  logic         rst,
    input  shift_cmd_t   cmd_i,
    output logic [K-1:0] rem_q_o,
    output logic [K-1:0] rem_next_o
);

    logic [K-1:0] rem_q;
    logic [K-1:0] stepped;
    logic         top_bit;

    assign top_bit = rem_q[K-1];

    // One division step: shift left, new bit at the bottom, subtract
    // (XOR) the generator's low terms when the dropped bit was one.
    for (genvar g = 0; g < K; g++) begin : g_tap
        if (g == 0) begin : g_lsb
            assign stepped[g] = cmd_i.din ^ (top_bit & GEN[g]);
        end else begin : g_mid
            assign stepped[g] = rem_q[g-1] ^ (top_bit & GEN[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (cmd_i.clr) begin
            rem_q <= '0;
        end else if (cmd_i.en) begin
            rem_q <= stepped;
        end
    end

    assign rem_q_o    = rem_q;
    assign rem_next_o = stepped;

endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
    import crc_serial_pkg::*;
#(
    parameter int K = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       mode_i,
    input  logic       valid_i,
    input  logic       data_i,
    input  logic       end_i,
    output shift_cmd_t cmd_o,
    output logic       fin_o,
    output logic       ref_cap_o,
    output crc_mode_e  mode_q_o,
    output logic       busy_o
);

    localparam int CW = (K < 2) ? 1 : $clog2(K);
    localparam logic [CW-1:0] LAST = CW'(K - 1);

    crc_phase_e    ph_q, ph_d;
    logic [CW-1:0] cnt_q, cnt_d;
    crc_mode_e     mode_q;

    always_comb begin
        ph_d      = ph_q;
        cnt_d     = cnt_q;
        cmd_o     = SHIFT_IDLE;
        fin_o     = 1'b0;
        ref_cap_o = 1'b0;
        if (start_i) begin
            ph_d  = PH_DATA;
            cnt_d = '0;
            cmd_o = mk_clear();
        end else begin
            unique case (ph_q)
                PH_DATA: begin
                    if (valid_i) begin
                        cmd_o = mk_shift(data_i);
                    end
                    if (end_i) begin
                        ph_d      = PH_FLUSH;
                        cnt_d     = '0;
                        ref_cap_o = 1'b1;
                    end
                end
                PH_FLUSH: begin
                    cmd_o = mk_shift(1'b0);
                    if (cnt_q == LAST) begin
                        ph_d  = PH_IDLE;
                        fin_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    ph_d = PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            mode_q <= MODE_GEN;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            if (start_i) begin
                mode_q <= crc_mode_e'(mode_i);
            end
        end
    end

    assign mode_q_o = mode_q;
    assign busy_o   = (ph_q != PH_IDLE);

    // R8: busy only begins after a start strobe
    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R3: the zero-bit counter never passes the polynomial degree
    a_r3_flush_bounded: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_FLUSH) |-> (32'(cnt_q) < K));

endmodule

// File: rtl/crc_result_stage.sv
module crc_result_stage
    import crc_serial_pkg::*;
#(
    parameter int K = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fin_i,
    input  crc_mode_e    mode_i,
    input  logic         ref_cap_i,
    input  logic [K-1:0] ref_i,
    input  logic [K-1:0] rem_next_i,
    output logic [K-1:0] rem_o,
    output logic         done_o,
    output logic         mismatch_o
);

    logic [K-1:0] ref_q;
    logic         differs;

    assign differs = (rem_next_i != ref_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q      <= '0;
            rem_o      <= '0;
            done_o     <= 1'b0;
            mismatch_o <= 1'b0;
        end else begin
            done_o <= fin_i;
            if (ref_cap_i) begin
                ref_q <= ref_i;
            end
            if (fin_i) begin
                rem_o      <= rem_next_i;
                mismatch_o <= (mode_i == MODE_CHK) && differs;
            end
        end
    end

    // R3: the completion flag is a single-cycle pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: results move only together with the completion pulse
    a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(rem_o) && $stable(mismatch_o)));

endmodule

// File: rtl/crc_serial_codec.sv
module crc_serial_codec
    import crc_serial_pkg::*;
#(
    parameter int         K   = 3,
    parameter logic [K:0] GEN = 4'b1011
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_start_i,
    input  logic         check_mode_i,
    input  logic         bit_valid_i,
    input  logic         bit_i,
    input  logic         frame_end_i,
    input  logic [K-1:0] expect_i,
    output logic [K-1:0] remainder_o,
    output logic         done_o,
    output logic         mismatch_o,
    output logic         busy_o
);

    shift_cmd_t   cmd;
    logic         fin;
    logic         ref_cap;
    crc_mode_e    mode_q;
    logic [K-1:0] rem_q;
    logic [K-1:0] rem_next;

    crc_seq_ctrl #(.K(K)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (frame_start_i),
        .mode_i   (check_mode_i),
        .valid_i  (bit_valid_i),
        .data_i   (bit_i),
        .end_i    (frame_end_i),
        .cmd_o    (cmd),
        .fin_o    (fin),
        .ref_cap_o(ref_cap),
        .mode_q_o (mode_q),
        .busy_o   (busy_o)
    );

    crc_shift_core #(.K(K), .GEN(GEN)) u_core (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd),
        .rem_q_o   (rem_q),
        .rem_next_o(rem_next)
    );

    crc_result_stage #(.K(K)) u_res (
        .clk       (clk),
        .rst       (rst),
        .fin_i     (fin),
        .mode_i    (mode_q),
        .ref_cap_i (ref_cap),
        .ref_i     (expect_i),
        .rem_next_i(rem_next),
        .rem_o     (remainder_o),
        .done_o    (done_o),
        .mismatch_o(mismatch_o)
    );

    // R7: with no frame open and no start, the divider does not move
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !frame_start_i) |=> $stable(rem_q));

    // R8: busy falls on the same edge that raises done
    a_r8_idle_on_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

endmodule

// File: tb/sim_crc_serial_codec.sv
`timescale 1ns/1ps
module sim_crc_serial_codec;

    localparam int         K   = 3;
    localparam logic [K:0] GEN = 4'b1011;

    typedef struct {
        logic [K-1:0] rem;
        logic         mm;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         frame_start_i = 1'b0;
    logic         check_mode_i = 1'b0;
    logic         bit_valid_i = 1'b0;
    logic         bit_i = 1'b0;
    logic         frame_end_i = 1'b0;
    logic [K-1:0] expect_i = '0;
    logic [K-1:0] remainder_o;
    logic         done_o;
    logic         mismatch_o;
    logic         busy_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    crc_serial_codec #(.K(K), .GEN(GEN)) u0 (
        .clk(clk), .rst(rst),
        .frame_start_i(frame_start_i), .check_mode_i(check_mode_i),
        .bit_valid_i(bit_valid_i), .bit_i(bit_i),
        .frame_end_i(frame_end_i), .expect_i(expect_i),
        .remainder_o(remainder_o), .done_o(done_o),
        .mismatch_o(mismatch_o), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Long division of the augmented message, subtracting shifted generators
    function automatic logic [K-1:0] model_rem(input bit bits[$]);
        bit m[$];
        logic [K-1:0] r;
        m = bits;
        for (int i = 0; i < K; i++) m.push_back(1'b0);
        for (int i = 0; i < bits.size(); i++) begin
            if (m[i]) begin
                for (int j = 0; j <= K; j++) m[i+j] = m[i+j] ^ GEN[K-j];
            end
        end
        for (int j = 0; j < K; j++) r[K-1-j] = m[bits.size()+j];
        return r;
    endfunction

    // Monitor: pops expected results as done pulses appear (R4, R5)
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(remainder_o == e.rem, "R4", {e.tag, " remainder"},
                      int'(remainder_o), int'(e.rem));
                check(mismatch_o == e.mm, "R5", {e.tag, " mismatch"},
                      int'(mismatch_o), int'(e.mm));
            end
        end
    end

    // Driver: one frame; gaps inserts idle cycles, noise toggles inputs in flush
    task automatic run_frame(input bit mode, input bit bits[$], input logic [K-1:0] refv,
                             input bit gaps, input bit noise, input string tag,
                             input bit use_lit, input logic [K-1:0] lit);
        exp_t e;
        int   cyc;
        logic [K-1:0] r;
        r = use_lit ? lit : model_rem(bits);
        e.rem = r;
        e.mm  = mode && (r != refv);
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        frame_start_i = 1'b1; check_mode_i = mode; expect_i = refv;
        @(negedge clk);
        frame_start_i = 1'b0;
        check(busy_o == 1'b1, "R8", {tag, " busy after start"}, int'(busy_o), 1);
        if (bits.size() == 0) begin
            frame_end_i = 1'b1;
            @(negedge clk);
        end else begin
            for (int i = 0; i < bits.size(); i++) begin
                if (gaps) begin
                    bit_valid_i = 1'b0; bit_i = ~bits[i];
                    @(negedge clk);
                end
                bit_valid_i = 1'b1; bit_i = bits[i];
                frame_end_i = (i == bits.size() - 1);
                @(negedge clk);
            end
        end
        frame_end_i = 1'b0;
        bit_valid_i = noise; bit_i = noise;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!done_o && cyc < K + 4);
        bit_valid_i = 1'b0; bit_i = 1'b0;
        check(cyc == K, "R3", {tag, " done latency"}, cyc, K);
        check(busy_o == 1'b0, "R8", {tag, " idle at done"}, int'(busy_o), 0);
        @(negedge clk);
        check(done_o == 1'b0, "R3", {tag, " single pulse"}, int'(done_o), 0);
        check(remainder_o == r, "R6", {tag, " held"}, int'(remainder_o), int'(r));
    endtask

    initial begin
        bit ex[$];
        bit pat[$];
        bit empty[$];
        logic [K-1:0] hold;
        ex = '{1,1,0,1,0,0,1,1,1,0,1,1,0,0};

        // R1: reset values
        repeat (3) @(negedge clk);
        check(remainder_o == '0 && done_o == 0 && mismatch_o == 0 && busy_o == 0,
              "R1", "outputs in reset", int'({remainder_o, done_o, mismatch_o, busy_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(remainder_o == '0 && done_o == 0 && mismatch_o == 0 && busy_o == 0,
              "R1", "outputs after reset", int'({remainder_o, done_o, mismatch_o, busy_o}), 0);

        // R4: worked example against the literal 100
        run_frame(1'b0, ex, '0, 1'b0, 1'b0, "R4 worked example", 1'b1, 3'b100);
        // R2: same frame with idle gaps between bits
        run_frame(1'b0, ex, '0, 1'b1, 1'b0, "R2 gapped example", 1'b1, 3'b100);
        // R5: check mode, matching and mismatching received values
        run_frame(1'b1, ex, 3'b100, 1'b0, 1'b0, "R5 check match", 1'b0, '0);
        run_frame(1'b1, ex, 3'b101, 1'b0, 1'b0, "R5 check mismatch", 1'b0, '0);
        // R5: generate mode never flags, whatever expect_i holds
        run_frame(1'b0, ex, 3'b011, 1'b0, 1'b0, "R5 gen no flag", 1'b0, '0);
        // R9: empty frame
        run_frame(1'b1, empty, 3'b000, 1'b0, 1'b0, "R9 empty frame", 1'b1, 3'b000);

        // R7: inputs while idle are ignored
        hold = remainder_o;
        for (int i = 0; i < K + 4; i++) begin
            bit_valid_i = 1'b1; bit_i = i[0]; frame_end_i = i[1];
            @(negedge clk);
            check(done_o == 1'b0 && busy_o == 1'b0, "R7", "idle ignores inputs",
                  int'({done_o, busy_o}), 0);
        end
        bit_valid_i = 1'b0; frame_end_i = 1'b0;
        check(remainder_o == hold, "R7", "idle keeps remainder", int'(remainder_o), int'(hold));

        // R7: noise during flush ignored
        run_frame(1'b0, ex, '0, 1'b0, 1'b1, "R7 flush noise", 1'b1, 3'b100);

        // R7: abort a frame with a new start
        @(negedge clk);
        frame_start_i = 1'b1; check_mode_i = 1'b0;
        @(negedge clk);
        frame_start_i = 1'b0;
        for (int i = 0; i < 5; i++) begin
            bit_valid_i = 1'b1; bit_i = 1'b1;
            @(negedge clk);
        end
        bit_valid_i = 1'b0;
        pat = '{1,0,1};
        run_frame(1'b0, pat, '0, 1'b0, 1'b0, "R7 after abort", 1'b0, '0);

        // R4/R5: random frames
        for (int f = 0; f < 24; f++) begin
            bit rb[$];
            int n;
            bit md;
            logic [K-1:0] rv;
            n  = 1 + ($urandom % 40);
            for (int i = 0; i < n; i++) rb.push_back(bit'($urandom % 2));
            md = bit'(f % 2);
            rv = K'($urandom);
            if (f % 4 == 1) rv = model_rem(rb);
            run_frame(md, rb, rv, bit'((f / 2) % 2), 1'b0, "R4 random", 1'b0, '0);
        end

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R3", "all results seen", sb.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 50000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule